// File: doc/BRIEF.md
# Four-Channel PWM Generator with Staged Commit

The block produces four independent pulse-width modulated outputs from a single source clock. Each channel divides the clock by a programmable prescaler to form counter steps, counts steps up to a period modulus, and drives its output high for the first part of each period, as set by its duty value. Software programs the channels through a simple word-addressed register port. Read data comes back combinationally from the same address.

The prescale, modulus and duty values are staged. Writing prescale or modulus alone changes only what reads back. A write to the duty register commits all three staged values. On a running channel the commit waits until the current period ends, so no period ever mixes old and new settings. On a stopped channel it takes effect at once. Clearing the enable bit stops the output straight away, without finishing the period. Setting the bit restarts the channel's counters from zero with the settings most recently committed.

Top module: `pwm_bank`

## Requirements
- R1: `reg_addr` is a word address. Bits [4:3] select the channel, so each channel's window begins at channel × 32 bytes. Bits [2:0] select the register: word 0 (byte 0x0) is prescale, word 1 (0x4) is modulus, word 2 (0x8) is duty and word 6 (0x18) is enable.
- R2: A read returns the last value written, masked to its field: prescale is bits [7:0], modulus is bits [7:0], duty is bits [15:0] and enable is bit 0. All other bits read as zero, and unused word offsets read as zero.
- R3: With committed prescale P, modulus M and duty D on an enabled channel, the output in the t-th cycle after the enabling write is high exactly when floor(t/(P+1)) mod M < D.
- R4: A duty greater than or equal to the modulus gives a constant high output. A duty of zero gives a constant low output.
- R5: A modulus of zero behaves as a period of one step.
- R6: Writing prescale or modulus without a following duty write leaves the output unchanged.
- R7: On an enabled channel, a duty write commits the staged prescale, modulus and duty. The new values are applied at the first period boundary after the commit, so the period that is running completes with the old settings.
- R8: Writing 0 to enable drives the output low in the very next cycle, and the output stays low while the channel is disabled.
- R9: A commit made while the channel is disabled takes effect at once. Enabling the channel restarts the prescaler and the step counter from zero.
- R10: Each channel's output depends only on its own registers. Disabled channels stay low while another channel runs.
- R11: After reset, every output is low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address: channel in [4:3], register in [2:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
A write is captured at the clock edge that ends the cycle in which it is presented. Read data is valid in that same cycle. The enable and disable effects appear in the first cycle after the capturing edge, which the bench counts as t = 0. A duty commit reaches the channel one cycle later and, on a running channel, is applied at the next period boundary. The bench therefore issues writes well away from period ends. It samples every output at the falling edge and compares it with the value that R3's formula gives for that cycle index, switching formulas only at the boundary where the commit is due.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int PRE_W  = 8;
    localparam int MOD_W  = 8;
    localparam int DUTY_W = 16;
    localparam int DATA_W = 32;
    localparam int OFS_W  = 3;

    // word offsets inside one channel window
    localparam logic [OFS_W-1:0] OFS_PRE  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_MOD  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_DUTY = 3'd2;
    localparam logic [OFS_W-1:0] OFS_EN   = 3'd6;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MOD_W-1:0]  modv;
        logic [DUTY_W-1:0] duty;
    } pwm_cfg_t;

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + OFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output pwm_cfg_t [NUM_CH-1:0] stage,
    output logic [NUM_CH-1:0]     en,
    output logic [NUM_CH-1:0]     commit
);

    typedef struct packed {
        pwm_cfg_t [NUM_CH-1:0] cfg;
        logic [NUM_CH-1:0]     en;
        logic [NUM_CH-1:0]     commit;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic [CH_W-1:0]   sel_ch;
    logic [OFS_W-1:0]  sel_ofs;

    assign sel_ch  = addr[ADDR_W-1:OFS_W];
    assign sel_ofs = addr[OFS_W-1:0];

    always_comb begin
        regs_d        = regs_q;
        regs_d.commit = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (we && sel_ch == CH_W'(c)) begin
                case (sel_ofs)
                    OFS_PRE:  regs_d.cfg[c].pre  = wdata[PRE_W-1:0];
                    OFS_MOD:  regs_d.cfg[c].modv = wdata[MOD_W-1:0];
                    OFS_DUTY: begin
                        regs_d.cfg[c].duty = wdata[DUTY_W-1:0];
                        regs_d.commit[c]   = 1'b1;
                    end
                    OFS_EN:   regs_d.en[c]       = wdata[0];
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel_ch == CH_W'(c)) begin
                case (sel_ofs)
                    OFS_PRE:  rdata = DATA_W'(regs_q.cfg[c].pre);
                    OFS_MOD:  rdata = DATA_W'(regs_q.cfg[c].modv);
                    OFS_DUTY: rdata = DATA_W'(regs_q.cfg[c].duty);
                    OFS_EN:   rdata = DATA_W'(regs_q.en[c]);
                    default:  rdata = '0;
                endcase
            end
        end
    end

    assign stage  = regs_q.cfg;
    assign en     = regs_q.en;
    assign commit = regs_q.commit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_COMMIT_FROM_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
            regs_q.commit[g] |-> $past(we && sel_ch == CH_W'(g) && sel_ofs == OFS_DUTY)) // R7
            else $error("commit without duty write");
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  pwm_cfg_t stage,
    input  logic     commit,
    output logic     pwm
);

    typedef struct packed {
        pwm_cfg_t         act;
        pwm_cfg_t         pend;
        logic             pend_v;
        logic [PRE_W-1:0] pre_cnt;
        logic [MOD_W-1:0] step;
    } chan_t;

    chan_t            st_d, st_q;
    logic [MOD_W-1:0] last_step;
    logic             tick;
    logic             wrap;

    assign last_step = (st_q.act.modv == '0) ? '0 : st_q.act.modv - MOD_W'(1);
    assign tick      = (st_q.pre_cnt == st_q.act.pre);
    assign wrap      = tick && (st_q.step == last_step);

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.pre_cnt = '0;
            st_d.step    = '0;
            if (commit) begin
                st_d.act    = stage;
                st_d.pend_v = 1'b0;
            end else if (st_q.pend_v) begin
                st_d.act    = st_q.pend;
                st_d.pend_v = 1'b0;
            end
        end else begin
            st_d.pre_cnt = tick ? '0 : st_q.pre_cnt + PRE_W'(1);
            if (tick) st_d.step = wrap ? '0 : st_q.step + MOD_W'(1);
            if (commit) begin
                if (wrap) begin
                    st_d.act    = stage;
                    st_d.pend_v = 1'b0;
                end else begin
                    st_d.pend   = stage;
                    st_d.pend_v = 1'b1;
                end
            end else if (wrap && st_q.pend_v) begin
                st_d.act    = st_q.pend;
                st_d.pend_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm = en && (DUTY_W'(st_q.step) < st_q.act.duty);

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.step <= last_step) // R3
        else $error("step beyond period");
    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pre_cnt <= st_q.act.pre) // R3
        else $error("prescaler beyond limit");
    AST_NO_MIDPERIOD_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> $stable(st_q.act)) // R7
        else $error("settings changed inside a period");
    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.step == '0 && st_q.pre_cnt == '0)) // R9
        else $error("counters not cleared while disabled");

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int ADDR_W = $clog2(NUM_CH) + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    pwm_cfg_t [NUM_CH-1:0] stage;
    logic [NUM_CH-1:0]     en;
    logic [NUM_CH-1:0]     commit;

    pwm_bank_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .stage  (stage),
        .en     (en),
        .commit (commit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_bank_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en[g]),
            .stage  (stage[g]),
            .commit (commit[g]),
            .pwm    (pwm_out[g])
        );
    end

    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[OFS_W-1:0] == OFS_EN && !reg_wdata[0])
        |=> !pwm_out[reg_addr[ADDR_W-1:OFS_W]]) // R8
        else $error("output not stopped by disable");

endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    pwm_bank dut (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(int ch, int ofs, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = {ch[1:0], ofs[2:0]}; wdata = d;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic rd_chk(string req, int ch, int ofs, logic [31:0] exp);
        @(negedge clk);
        addr = {ch[1:0], ofs[2:0]};
        #1 check(req, rdata, exp);
    endtask

    function automatic logic wave(int t, int p, int m, int d);
        int em = (m == 0) ? 1 : m;
        return ((t / (p + 1)) % em) < d;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R11 reset state
        @(negedge clk);
        check("R11 outputs", {28'b0, pwm_out}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            rd_chk("R11 prescale", c, 0, 0);
            rd_chk("R11 duty", c, 2, 0);
            rd_chk("R11 enable", c, 6, 0);
        end

        // R1 R2 read-back, masking, unused offsets
        wr(3, 0, 32'hFFFF_FF5A);
        wr(3, 1, 32'h0000_12C3);
        wr(3, 2, 32'hABCD_8765);
        wr(1, 6, 32'hFFFF_FFFE);
        wr(0, 3, 32'hFFFF_FFFF);
        rd_chk("R2 prescale mask", 3, 0, 32'h5A);
        rd_chk("R2 modulus mask", 3, 1, 32'hC3);
        rd_chk("R2 duty mask", 3, 2, 32'h8765);
        rd_chk("R2 enable bit0", 1, 6, 32'h0);
        rd_chk("R2 unused offset", 0, 3, 32'h0);
        rd_chk("R1 other channel untouched", 2, 0, 32'h0);
        wr(1, 6, 32'h1);
        rd_chk("R1 enable word 6", 1, 6, 32'h1);
        wr(1, 6, 32'h0);

        // R3 R4 R5 R10 sweep: every channel, several prescale/modulus/duty values
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 3; p++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int d = 0; d < 5; d++) begin
                        int pv = (p == 2) ? 3 : p;
                        int mv = (m == 3) ? 5 : m;
                        int dv = (d == 4) ? 7 : d;
                        int em = (mv == 0) ? 1 : mv;
                        wr(c, 6, 0);
                        wr(c, 0, pv);
                        wr(c, 1, mv);
                        wr(c, 2, dv);
                        wr(c, 6, 1);
                        for (int t = 0; t < 2 * (pv + 1) * em + 2; t++) begin
                            logic [3:0] ev;
                            @(negedge clk);
                            ev = '0;
                            ev[c] = wave(t, pv, mv, dv);
                            // R3 R4 R5 waveform, R10 other channels low
                            check("R3/R4/R5/R10 sweep", {28'b0, pwm_out}, {28'b0, ev});
                        end
                    end
                end
            end
            wr(c, 6, 0);
        end

        // R6 R7 staged commit on channel 1
        wr(1, 0, 0);
        wr(1, 1, 8);
        wr(1, 2, 2);
        wr(1, 6, 1);
        for (int t = 0; t < 40; t++) begin
            logic ev;
            @(negedge clk);
            we = 1'b0;
            ev = (t < 24) ? wave(t, 0, 8, 2) : wave(t - 24, 1, 4, 1);
            if (t < 24) check("R6 uncommitted writes ignored", {31'b0, pwm_out[1]}, {31'b0, ev});
            else        check("R7 commit at period boundary", {31'b0, pwm_out[1]}, {31'b0, ev});
            if (t == 1)  begin we = 1'b1; addr = {2'd1, 3'd1}; wdata = 4; end
            if (t == 10) begin we = 1'b1; addr = {2'd1, 3'd0}; wdata = 1; end
            if (t == 18) begin we = 1'b1; addr = {2'd1, 3'd2}; wdata = 1; end
        end
        wr(1, 6, 0);

        // R8 R9 immediate disable, commit while disabled, restart from zero
        wr(2, 0, 0);
        wr(2, 1, 10);
        wr(2, 2, 8);
        wr(2, 6, 1);
        for (int t = 0; t < 32; t++) begin
            logic ev;
            @(negedge clk);
            we = 1'b0;
            if (t < 4)       ev = wave(t, 0, 10, 8);
            else if (t < 11) ev = 1'b0;
            else             ev = wave(t - 11, 0, 10, 3);
            if (t < 11) check("R8 disable immediate", {31'b0, pwm_out[2]}, {31'b0, ev});
            else        check("R9 restart with new settings", {31'b0, pwm_out[2]}, {31'b0, ev});
            if (t == 3)  begin we = 1'b1; addr = {2'd2, 3'd6}; wdata = 0; end
            if (t == 5)  begin we = 1'b1; addr = {2'd2, 3'd2}; wdata = 3; end
            if (t == 10) begin we = 1'b1; addr = {2'd2, 3'd6}; wdata = 1; end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule